// File: doc/BRIEF.md
# Ethernet PHY Operating Mode Controller

This block holds the 16-bit basic control register of an Ethernet PHY and works out from it the mode the PHY actually runs in. A management agent writes and reads the register through a one-cycle write strobe and a one-cycle read strobe. Three strap pins choose between hardware and software configuration and give the rate and the auto-negotiation setting to use in hardware configuration. A negotiation result input supplies the negotiated speed and duplex once negotiation completes.

The block drives the resolved speed, duplex and auto-negotiation enable. It also drives the loopback state and enables for the line transmitter, the line receiver and collision detection. A link-rate status bit tracks the resolved speed while the link is up. In loopback a short fixed pipeline carries the transmit nibble stream back to the receive outputs.

Register bits the block defines: bit 15 soft reset, bit 14 loopback, bit 13 speed select, bit 12 auto-negotiation enable, bit 8 duplex select, bit 7 collision-detect keep. Every other bit reads as zero. Bits 13, 12 and 8 reset to one, so the default value is 0x3100.

Top module: `phy_mode_ctrl`

## Requirements
- R1: A write stores bits 14, 13, 12, 8 and 7 of the write data. A read strobe returns the register on `mgmt_rdata` on the following clock edge, and all other bits read zero.
- R2: A write with bit 15 set returns the register to 0x3100 by the next edge. Bit 15 always reads zero, and loopback is off two edges after that write.
- R3: When `strap_sw` is 0 (hardware configuration), speed follows `strap_rate100` and auto-negotiation enable follows `strap_an_sel`. Register bits 13 and 12 have no effect.
- R4: When `strap_sw` is 0, a read returns zero in bits 13 and 12.
- R5: When auto-negotiation is enabled and `an_done` is 1, `eff_speed100` and `eff_full_dup` follow `an_speed100` and `an_full_dup`. Register bits 13 and 8 have no effect.
- R6: When auto-negotiation is enabled and `an_done` is 0, the resolved mode is 10 Mbps half duplex (both outputs 0).
- R7: When auto-negotiation is disabled, bit 8 gives the duplex (1 = full). In software configuration bit 13 gives the speed (0 = 10 Mbps, 1 = 100 Mbps).
- R8: With bit 14 set, `lpbk_on` is 1 and both `line_tx_en` and `line_rx_en` are 0. `col_det_en` is 0 unless bit 7 is 1. With bit 14 clear, all three enables are 1.
- R9: In loopback, `rx_dv` and `rxd` repeat `tx_en` and `txd` exactly LOOP_LAT (default 3) clock edges later. With loopback off, `tx_en` never raises `rx_dv`.
- R10: While `link_up` is 1, `speed_stat` matches the resolved speed. While `link_up` is 0, it holds its last value.
- R11: All resolved outputs change on the first clock edge after the register or input that drives them changes. Reset gives 0 on the resolved outputs and 1 on the three line enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (nibble clock) |
| rst | input | 1 | Synchronous active-high reset |
| mgmt_wr | input | 1 | Register write strobe |
| mgmt_rd | input | 1 | Register read strobe |
| mgmt_wdata | input | 16 | Register write data |
| mgmt_rdata | output | 16 | Register read data, valid one edge after `mgmt_rd` |
| strap_sw | input | 1 | 1 = software configuration, 0 = hardware configuration |
| strap_rate100 | input | 1 | Hardware rate: 1 = 100 Mbps |
| strap_an_sel | input | 1 | Hardware auto-negotiation enable |
| an_done | input | 1 | Negotiation complete |
| an_speed100 | input | 1 | Negotiated speed, 1 = 100 Mbps |
| an_full_dup | input | 1 | Negotiated duplex, 1 = full |
| link_up | input | 1 | Link is active |
| tx_en | input | 1 | Transmit enable from the MAC side |
| txd | input | DATA_W | Transmit nibble |
| rx_dv | output | 1 | Receive data valid |
| rxd | output | DATA_W | Receive nibble |
| eff_speed100 | output | 1 | Resolved speed, 1 = 100 Mbps |
| eff_full_dup | output | 1 | Resolved duplex, 1 = full |
| eff_an_en | output | 1 | Resolved auto-negotiation enable |
| lpbk_on | output | 1 | Loopback active |
| line_tx_en | output | 1 | Line transmitter enable |
| line_rx_en | output | 1 | Line receiver enable |
| col_det_en | output | 1 | Collision detection enable |
| speed_stat | output | 1 | Active link rate status |

## Verification
The assertions assume that the straps and negotiation inputs change only between clock edges. They also assume that `mgmt_wr` and `mgmt_rd` are single-cycle pulses and that a read is not issued in the same cycle as a write whose effect it must see. The bench drives every input on the falling edge. It holds each strobe for exactly one cycle and leaves at least one idle cycle between a write and the read or check that depends on it, so every sample follows the settled registered outputs.

// File: rtl/phy_mode_pkg.sv
package phy_mode_pkg;
  localparam int REG_W      = 16;
  localparam int B_SRST     = 15;
  localparam int B_LOOP     = 14;
  localparam int B_SPEED    = 13;
  localparam int B_ANEN     = 12;
  localparam int B_DUPLEX   = 8;
  localparam int B_COLKEEP  = 7;
  localparam logic [REG_W-1:0] CTL_DEFAULT = 16'h3100;
  localparam logic [REG_W-1:0] CTL_MASK =
    (16'h1 << B_LOOP) | (16'h1 << B_SPEED) | (16'h1 << B_ANEN) |
    (16'h1 << B_DUPLEX) | (16'h1 << B_COLKEEP);
  localparam logic [REG_W-1:0] HW_HIDE = (16'h1 << B_SPEED) | (16'h1 << B_ANEN);
endpackage

// File: rtl/pmc_ctl_reg.sv
module pmc_ctl_reg
  import phy_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [REG_W-1:0] wdata,
  input  logic             hw_mode,
  output logic [REG_W-1:0] ctl,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl <= CTL_DEFAULT;
    end else if (wr) begin
      if (wdata[B_SRST]) ctl <= CTL_DEFAULT;
      else               ctl <= wdata & CTL_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= hw_mode ? (ctl & ~HW_HIDE) : ctl;
    end
  end
endmodule

// File: rtl/pmc_resolve.sv
module pmc_resolve
  import phy_mode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] ctl,
  input  logic             strap_sw,
  input  logic             strap_rate100,
  input  logic             strap_an_sel,
  input  logic             an_done,
  input  logic             an_speed100,
  input  logic             an_full_dup,
  input  logic             link_up,
  output logic             eff_speed100,
  output logic             eff_full_dup,
  output logic             eff_an_en,
  output logic             lpbk_on,
  output logic             line_tx_en,
  output logic             line_rx_en,
  output logic             col_det_en,
  output logic             speed_stat
);
  logic an_en_n, spd_n, dup_n, loop_n;

  always_comb begin
    an_en_n = strap_sw ? ctl[B_ANEN] : strap_an_sel;
    if (an_en_n) begin
      spd_n = an_done & an_speed100;
      dup_n = an_done & an_full_dup;
    end else begin
      spd_n = strap_sw ? ctl[B_SPEED] : strap_rate100;
      dup_n = ctl[B_DUPLEX];
    end
    loop_n = ctl[B_LOOP];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_speed100 <= 1'b0;
      eff_full_dup <= 1'b0;
      eff_an_en    <= 1'b0;
      lpbk_on      <= 1'b0;
      line_tx_en   <= 1'b1;
      line_rx_en   <= 1'b1;
      col_det_en   <= 1'b1;
      speed_stat   <= 1'b0;
    end else begin
      eff_speed100 <= spd_n;
      eff_full_dup <= dup_n;
      eff_an_en    <= an_en_n;
      lpbk_on      <= loop_n;
      line_tx_en   <= ~loop_n;
      line_rx_en   <= ~loop_n;
      col_det_en   <= ~loop_n | ctl[B_COLKEEP];
      if (link_up) speed_stat <= spd_n;
    end
  end
endmodule

// File: rtl/pmc_loop.sv
module pmc_loop #(
  parameter int DATA_W = 4,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] txd,
  output logic              rx_dv,
  output logic [DATA_W-1:0] rxd
);
  localparam int LAST = LAT - 1;

  logic [LAT-1:0]    dv_q;
  logic [DATA_W-1:0] d_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q   <= '0;
      d_q[0] <= '0;
    end else begin
      dv_q[0] <= en & tx_en;
      d_q[0]  <= (en & tx_en) ? txd : '0;
    end
  end

  for (genvar s = 1; s < LAT; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        dv_q[s] <= 1'b0;
        d_q[s]  <= '0;
      end else begin
        dv_q[s] <= dv_q[s-1];
        d_q[s]  <= d_q[s-1];
      end
    end
  end

  assign rx_dv = dv_q[LAST];
  assign rxd   = d_q[LAST];
endmodule

// File: rtl/phy_mode_ctrl.sv
module phy_mode_ctrl
  import phy_mode_pkg::*;
#(
  parameter int DATA_W   = 4,
  parameter int LOOP_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mgmt_wr,
  input  logic              mgmt_rd,
  input  logic [15:0]       mgmt_wdata,
  output logic [15:0]       mgmt_rdata,
  input  logic              strap_sw,
  input  logic              strap_rate100,
  input  logic              strap_an_sel,
  input  logic              an_done,
  input  logic              an_speed100,
  input  logic              an_full_dup,
  input  logic              link_up,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] txd,
  output logic              rx_dv,
  output logic [DATA_W-1:0] rxd,
  output logic              eff_speed100,
  output logic              eff_full_dup,
  output logic              eff_an_en,
  output logic              lpbk_on,
  output logic              line_tx_en,
  output logic              line_rx_en,
  output logic              col_det_en,
  output logic              speed_stat
);
  logic [REG_W-1:0] ctl;

  pmc_ctl_reg u_reg (
    .clk(clk), .rst(rst), .wr(mgmt_wr), .rd(mgmt_rd), .wdata(mgmt_wdata),
    .hw_mode(~strap_sw), .ctl(ctl), .rdata(mgmt_rdata)
  );

  pmc_resolve u_res (
    .clk(clk), .rst(rst), .ctl(ctl), .strap_sw(strap_sw),
    .strap_rate100(strap_rate100), .strap_an_sel(strap_an_sel),
    .an_done(an_done), .an_speed100(an_speed100), .an_full_dup(an_full_dup),
    .link_up(link_up), .eff_speed100(eff_speed100), .eff_full_dup(eff_full_dup),
    .eff_an_en(eff_an_en), .lpbk_on(lpbk_on), .line_tx_en(line_tx_en),
    .line_rx_en(line_rx_en), .col_det_en(col_det_en), .speed_stat(speed_stat)
  );

  pmc_loop #(.DATA_W(DATA_W), .LAT(LOOP_LAT)) u_loop (
    .clk(clk), .rst(rst), .en(ctl[B_LOOP]), .tx_en(tx_en), .txd(txd),
    .rx_dv(rx_dv), .rxd(rxd)
  );
endmodule

// File: rtl/phy_mode_ctrl_chk.sv
module phy_mode_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        mgmt_wr,
  input logic        mgmt_rd,
  input logic [15:0] mgmt_wdata,
  input logic [15:0] mgmt_rdata,
  input logic        strap_sw,
  input logic        an_done,
  input logic        link_up,
  input logic        eff_speed100,
  input logic        eff_full_dup,
  input logic        eff_an_en,
  input logic        lpbk_on,
  input logic        line_tx_en,
  input logic        line_rx_en,
  input logic        col_det_en,
  input logic        speed_stat
);
  // R8
  loop_line_off_chk: assert property (@(posedge clk) disable iff (rst)
    lpbk_on |-> (!line_tx_en && !line_rx_en));
  // R8
  col_on_outside_loop_chk: assert property (@(posedge clk) disable iff (rst)
    !lpbk_on |-> (col_det_en && line_tx_en && line_rx_en));
  // R6
  an_pending_low_chk: assert property (@(posedge clk) disable iff (rst)
    (eff_an_en && !$past(an_done)) |-> (!eff_speed100 && !eff_full_dup));
  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !link_up |=> $stable(speed_stat));
  // R4
  hw_read_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mgmt_rd && !strap_sw) |=> (mgmt_rdata[13:12] == 2'b00));
  // R2
  soft_reset_loop_chk: assert property (@(posedge clk) disable iff (rst)
    (mgmt_wr && mgmt_wdata[15]) |=> ##1 !lpbk_on);
  // R1
  srst_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mgmt_rdata[15]);
endmodule

bind phy_mode_ctrl phy_mode_ctrl_chk u_chk (.*);

// File: tb/phy_mode_ctrl_test.sv
`timescale 1ns/1ps
module phy_mode_ctrl_test;
  logic clk = 1'b0;
  logic rst;
  logic mgmt_wr, mgmt_rd;
  logic [15:0] mgmt_wdata, mgmt_rdata;
  logic strap_sw, strap_rate100, strap_an_sel;
  logic an_done, an_speed100, an_full_dup, link_up;
  logic tx_en;
  logic [3:0] txd, rxd;
  logic rx_dv, eff_speed100, eff_full_dup, eff_an_en;
  logic lpbk_on, line_tx_en, line_rx_en, col_det_en, speed_stat;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  phy_mode_ctrl uut (.*);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [15:0] v);
    mgmt_wr = 1'b1; mgmt_wdata = v;
    cyc(1);
    mgmt_wr = 1'b0; mgmt_wdata = '0;
    cyc(2);
  endtask

  task automatic rd_reg(output logic [15:0] v);
    mgmt_rd = 1'b1;
    cyc(1);
    mgmt_rd = 1'b0;
    v = mgmt_rdata;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd_reg(v);
    check("R1 default read", v, 16'h3100);
    check("R11 reset outputs", {eff_speed100, eff_full_dup, eff_an_en, lpbk_on,
          line_tx_en, line_rx_en, col_det_en}, 16'b0010111);
  endtask

  task automatic t_regrw;
    logic [15:0] v;
    wr_reg(16'h7FFF);
    rd_reg(v);
    check("R1 masked write", v, 16'h7180);
    wr_reg(16'h0000);
    rd_reg(v);
    check("R1 clear write", v, 16'h0000);
  endtask

  task automatic t_selfclear;
    logic [15:0] v;
    wr_reg(16'h4000);
    check("R8 loop set", {15'd0, lpbk_on}, 16'd1);
    wr_reg(16'hC000);
    rd_reg(v);
    check("R2 soft reset value", v, 16'h3100);
    check("R2 loop cleared", {15'd0, lpbk_on}, 16'd0);
  endtask

  task automatic t_hw;
    logic [15:0] v;
    strap_sw = 1'b0; strap_rate100 = 1'b1; strap_an_sel = 1'b0;
    wr_reg(16'h0000);
    check("R3 hw rate strap", {14'd0, eff_speed100, eff_an_en}, 16'b10);
    wr_reg(16'h3000);
    strap_rate100 = 1'b0;
    cyc(2);
    check("R3 hw bits ignored", {14'd0, eff_speed100, eff_an_en}, 16'b00);
    check("R7 hw duplex bit8", {15'd0, eff_full_dup}, 16'd0);
    rd_reg(v);
    check("R4 hw read mask", v, 16'h0000);
    strap_an_sel = 1'b1; an_done = 1'b1; an_speed100 = 1'b1; an_full_dup = 1'b1;
    cyc(2);
    check("R3 hw an strap", {13'd0, eff_speed100, eff_full_dup, eff_an_en}, 16'b111);
    strap_sw = 1'b1; an_done = 1'b0; an_speed100 = 1'b0; an_full_dup = 1'b0;
    cyc(2);
  endtask

  task automatic t_an;
    wr_reg(16'h1000);
    an_done = 1'b1; an_speed100 = 1'b1; an_full_dup = 1'b1;
    cyc(2);
    check("R5 an result", {13'd0, eff_speed100, eff_full_dup, eff_an_en}, 16'b111);
    wr_reg(16'h3100);
    an_speed100 = 1'b0; an_full_dup = 1'b0;
    cyc(2);
    check("R5 bits 13/8 ignored", {14'd0, eff_speed100, eff_full_dup}, 16'b00);
    an_done = 1'b0; an_speed100 = 1'b1; an_full_dup = 1'b1;
    cyc(2);
    check("R6 an pending", {13'd0, eff_speed100, eff_full_dup, eff_an_en}, 16'b001);
  endtask

  task automatic t_forced;
    an_done = 1'b1; an_speed100 = 1'b0; an_full_dup = 1'b0;
    wr_reg(16'h2100);
    check("R7 forced 100 full", {13'd0, eff_speed100, eff_full_dup, eff_an_en}, 16'b110);
    an_speed100 = 1'b1; an_full_dup = 1'b1;
    wr_reg(16'h0000);
    check("R7 forced 10 half", {13'd0, eff_speed100, eff_full_dup, eff_an_en}, 16'b000);
    an_done = 1'b0;
  endtask

  task automatic t_loop;
    wr_reg(16'h4000);
    check("R8 loop no keep", {12'd0, lpbk_on, line_tx_en, line_rx_en, col_det_en}, 16'b1000);
    wr_reg(16'h4080);
    check("R8 loop keep col", {12'd0, lpbk_on, line_tx_en, line_rx_en, col_det_en}, 16'b1001);
    wr_reg(16'h0080);
    check("R8 loop off", {12'd0, lpbk_on, line_tx_en, line_rx_en, col_det_en}, 16'b0111);
  endtask

  task automatic t_lpdata;
    int seen = 0;
    wr_reg(16'h4000);
    tx_en = 1'b1; txd = 4'hA;
    cyc(1);
    tx_en = 1'b0; txd = 4'h0;
    cyc(1);
    check("R9 not yet valid", {15'd0, rx_dv}, 16'd0);
    cyc(1);
    check("R9 looped nibble", {11'd0, rx_dv, rxd}, {11'd0, 1'b1, 4'hA});
    cyc(1);
    check("R9 pulse ends", {15'd0, rx_dv}, 16'd0);
    wr_reg(16'h0000);
    tx_en = 1'b1; txd = 4'h5;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      if (rx_dv) seen++;
    end
    tx_en = 1'b0; txd = 4'h0;
    check("R9 no loop when off", 16'(seen), 16'd0);
  endtask

  task automatic t_speedstat;
    link_up = 1'b1;
    wr_reg(16'h2000);
    check("R10 stat follows", {15'd0, speed_stat}, 16'd1);
    link_up = 1'b0;
    wr_reg(16'h0000);
    check("R10 stat holds", {14'd0, eff_speed100, speed_stat}, 16'b01);
    link_up = 1'b1;
    cyc(2);
    check("R10 stat resumes", {15'd0, speed_stat}, 16'd0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst = 1'b1; mgmt_wr = 1'b0; mgmt_rd = 1'b0; mgmt_wdata = '0;
    strap_sw = 1'b1; strap_rate100 = 1'b0; strap_an_sel = 1'b0;
    an_done = 1'b0; an_speed100 = 1'b0; an_full_dup = 1'b0; link_up = 1'b0;
    tx_en = 1'b0; txd = '0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_regrw();
    t_selfclear();
    t_hw();
    t_an();
    t_forced();
    t_loop();
    t_lpdata();
    t_speedstat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule